// File: doc/BRIEF.md
# Sub-word configuration access adapter

The adapter sits between a host that issues configuration requests of 8, 16 or 32 bits and a downstream bridge port that can only move aligned 32-bit words. That port has two registers: an address register and a data register. Each host request carries a bus number, a device/function number, a register offset, a size code, a write flag and right-aligned write data. The adapter checks that the target is reachable and builds the configuration address word, choosing a Type 0 or a Type 1 cycle. It then runs the needed downstream cycles as a write of the address register followed by a data register access. It returns one response carrying data and a found flag.

The bridge shows configuration space in big-endian order, so the adapter swaps byte lanes for sub-word accesses. Sub-word writes become a read of the whole word, a merge of the new lane and a write of the whole word back. A downstream cycle that receives neither completion nor error within a set number of cycles is ended by the adapter. A read cycle ended this way, or by an error, supplies all-ones data, and the request is still reported as found.

Top module: `cfgx_adapter`

## Requirements
- R1: `req_ready` is high only while the adapter is idle, and it drops in the cycle after a request is accepted, so only one request is in flight. Every accepted request yields exactly one `rsp_valid` pulse, one cycle long. After reset `req_ready`=1, `rsp_valid`=0 and `dn_req`=0.
- R2: The address word written downstream has these fields: bits 31:24 = 0, bits 23:16 = bus, bits 15:8 = device/function, bits 7:2 = offset[7:2], bit 1 = 0, and bit 0 = 1 exactly when the bus is nonzero (Type 1) and 0 for bus 0 (Type 0).
- R3: Every downstream access writes the address register (`dn_addr`=ADDR_REG_OFS, default 0x500, `dn_we`=1) before it reads or writes the data register (`dn_addr`=DATA_REG_OFS, default 0x504).
- R4: A request with bus > 7 or device/function > 127 makes no downstream cycle. It responds with `rsp_found`=0 and all-ones data at the requested size: 0x000000FF, 0x0000FFFF or 0xFFFFFFFF.
- R5: Size code 0 is a byte. A byte read returns, in `rsp_data[7:0]` with the upper bits zero, the byte of the read word at bits [8k+7:8k], where k = offset[1:0] XOR 3.
- R6: Size code 1 is 16 bits. A 16-bit read returns, in `rsp_data[15:0]` with the upper bits zero, the half at bits [16h+15:16h], where h = offset[1] XOR 1. Offset bit 0 is ignored.
- R7: Size codes 2 and 3 are 32 bits. A 32-bit read returns the whole data-register word, and offset bits 1:0 are ignored.
- R8: A byte or 16-bit write makes four downstream cycles in this order: address write, data read, address write, data write. The last cycle writes the word read back with only the R5/R6 lane replaced by the low bits of `req_wdata`.
- R9: A 32-bit write makes exactly two downstream cycles, an address write and a data write of `req_wdata`, and never reads the data register.
- R10: A downstream cycle ends on `dn_done`, on `dn_err`, or after TIMEOUT_CYCLES cycles of `dn_req` with neither. A data read ended by an error or a timeout supplies 0xFFFFFFFF as the read word, and the response keeps `rsp_found`=1.
- R11: While `dn_req` is high, `dn_addr`, `dn_we` and `dn_wdata` do not change.
- R12: Write responses carry `rsp_data`=0 and `rsp_found`=1 when the target is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Adapter ready to accept a request |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function number |
| req_offset | input | 8 | Register byte offset |
| req_size | input | 2 | 0 byte, 1 sixteen bits, 2 or 3 thirty-two bits |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Right-aligned write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_found | output | 1 | Target accepted (0 for refused targets) |
| rsp_data | output | 32 | Right-aligned read data |
| dn_req | output | 1 | Downstream cycle request, held until it ends |
| dn_addr | output | DN_ADDR_W | Register offset: address register or data register |
| dn_we | output | 1 | Downstream write enable |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid with dn_done |
| dn_done | input | 1 | Downstream completion pulse |
| dn_err | input | 1 | Downstream error pulse |

## Verification
The assertions take for granted three things about the downstream side. `dn_done` and `dn_err` arrive only while `dn_req` is high. They last at most one cycle. The host holds its request fields steady while `req_valid` waits for `req_ready`. The bench's bridge model raises a completion for one cycle, two cycles after it first sees a request. It drops the pulse before the adapter can start another cycle. For one chosen device/function it stays silent on data accesses so the timeout path runs, and for another it answers data accesses with an error. The driver drives requests on falling edges and keeps them until they are accepted, so the fields never move while a request is pending.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int CFG_W   = 32;
    localparam int FIELD_W = 8;
    localparam int LANES   = CFG_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } cfgx_size_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WR_ADDR,
        ST_RD_DATA,
        ST_MERGE,
        ST_WR_ADDR2,
        ST_WR_DATA,
        ST_RESPOND
    } cfgx_state_e;

    typedef struct packed {
        logic [FIELD_W-1:0] bus;
        logic [FIELD_W-1:0] devfn;
        logic [FIELD_W-1:0] offset;
        cfgx_size_e         size;
        logic               write;
        logic [CFG_W-1:0]   wdata;
    } cfgx_req_t;

    function automatic logic is_full(input cfgx_size_e sz);
        return sz[1];
    endfunction

    function automatic logic [1:0] byte_lane(input logic [FIELD_W-1:0] ofs);
        return ofs[1:0] ^ 2'b11;
    endfunction

    function automatic logic half_lane(input logic [FIELD_W-1:0] ofs);
        return ~ofs[1];
    endfunction

    function automatic logic [CFG_W-1:0] ones_at(input cfgx_size_e sz);
        case (sz)
            SZ_BYTE: return {{(CFG_W-8){1'b0}}, 8'hFF};
            SZ_HALF: return {{(CFG_W-16){1'b0}}, 16'hFFFF};
            default: return {CFG_W{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/cfgx_target_check.sv
module cfgx_target_check
    import cfgx_pkg::*;
#(
    parameter int MAX_BUS   = 7,
    parameter int MAX_DEVFN = 127
) (
    input  logic [FIELD_W-1:0] bus,
    input  logic [FIELD_W-1:0] devfn,
    input  logic [FIELD_W-1:0] offset,
    output logic               target_ok,
    output logic [CFG_W-1:0]   addr_word
);
    localparam logic [FIELD_W-1:0] BUS_LIM   = FIELD_W'(MAX_BUS);
    localparam logic [FIELD_W-1:0] DEVFN_LIM = FIELD_W'(MAX_DEVFN);
    localparam int PAD_W = CFG_W - 3 * FIELD_W;

    logic type1;

    always_comb begin
        target_ok = (bus <= BUS_LIM) && (devfn <= DEVFN_LIM);
        type1     = (bus != '0);
        addr_word = {{PAD_W{1'b0}}, bus, devfn, offset[FIELD_W-1:2], 1'b0, type1};
    end
endmodule

// File: rtl/cfgx_lane_steer.sv
module cfgx_lane_steer
    import cfgx_pkg::*;
(
    input  logic [CFG_W-1:0]   word,
    input  logic [FIELD_W-1:0] offset,
    input  cfgx_size_e         size,
    input  logic [CFG_W-1:0]   wdata,
    output logic [CFG_W-1:0]   rd_val,
    output logic [CFG_W-1:0]   merged
);
    logic [1:0]       blane;
    logic             hlane;
    logic [CFG_W-1:0] ins;

    always_comb begin
        blane = byte_lane(offset);
        hlane = half_lane(offset);
        case (size)
            SZ_BYTE: begin
                ins    = {LANES{wdata[7:0]}};
                rd_val = {{(CFG_W-8){1'b0}}, word[8*blane +: 8]};
            end
            SZ_HALF: begin
                ins    = {(LANES/2){wdata[15:0]}};
                rd_val = {{(CFG_W-16){1'b0}}, word[16*hlane +: 16]};
            end
            default: begin
                ins    = wdata;
                rd_val = word;
            end
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic hit;
        always_comb begin
            case (size)
                SZ_BYTE: hit = (blane == 2'(i));
                SZ_HALF: hit = (hlane == 1'(i / 2));
                default: hit = 1'b1;
            endcase
        end
        assign merged[8*i +: 8] = hit ? ins[8*i +: 8] : word[8*i +: 8];
    end
endmodule

// File: rtl/cfgx_dn_port.sv
module cfgx_dn_port
    import cfgx_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 16,
    parameter int ADDR_W         = 12,
    parameter logic [ADDR_W-1:0] ADDR_REG_OFS = 12'h500,
    parameter logic [ADDR_W-1:0] DATA_REG_OFS = 12'h504
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              sel_data,
    input  logic              we,
    input  logic [CFG_W-1:0]  wdata,
    output logic              dn_req,
    output logic [ADDR_W-1:0] dn_addr,
    output logic              dn_we,
    output logic [CFG_W-1:0]  dn_wdata,
    input  logic [CFG_W-1:0]  dn_rdata,
    input  logic              dn_done,
    input  logic              dn_err,
    output logic              fin,
    output logic [CFG_W-1:0]  rdata
);
    localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [CNT_W-1:0] wait_cnt;
    logic             expired;

    assign expired = (wait_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            dn_req   <= 1'b0;
            dn_addr  <= ADDR_REG_OFS;
            dn_we    <= 1'b0;
            dn_wdata <= '0;
            wait_cnt <= '0;
            fin      <= 1'b0;
            rdata    <= '0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                dn_req   <= 1'b1;
                dn_addr  <= sel_data ? DATA_REG_OFS : ADDR_REG_OFS;
                dn_we    <= we;
                dn_wdata <= wdata;
                wait_cnt <= '0;
            end else if (dn_req) begin
                if (dn_done || dn_err || expired) begin
                    dn_req <= 1'b0;
                    fin    <= 1'b1;
                    rdata  <= (dn_done && !dn_err) ? dn_rdata : {CFG_W{1'b1}};
                end else begin
                    wait_cnt <= wait_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cfgx_adapter.sv
module cfgx_adapter
    import cfgx_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 16,
    parameter int DN_ADDR_W      = 12,
    parameter logic [DN_ADDR_W-1:0] ADDR_REG_OFS = 12'h500,
    parameter logic [DN_ADDR_W-1:0] DATA_REG_OFS = 12'h504,
    parameter int MAX_BUS        = 7,
    parameter int MAX_DEVFN      = 127
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [7:0]           req_bus,
    input  logic [7:0]           req_devfn,
    input  logic [7:0]           req_offset,
    input  logic [1:0]           req_size,
    input  logic                 req_write,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_found,
    output logic [31:0]          rsp_data,
    output logic                 dn_req,
    output logic [DN_ADDR_W-1:0] dn_addr,
    output logic                 dn_we,
    output logic [31:0]          dn_wdata,
    input  logic [31:0]          dn_rdata,
    input  logic                 dn_done,
    input  logic                 dn_err
);
    cfgx_state_e      state;
    cfgx_req_t        req_q;
    logic             ok_q;
    logic [CFG_W-1:0] aw_q;
    logic [CFG_W-1:0] word_q;
    logic             issued;

    logic             tgt_ok;
    logic [CFG_W-1:0] tgt_aw;
    logic [CFG_W-1:0] st_rd;
    logic [CFG_W-1:0] st_merged;

    logic             p_start;
    logic             p_sel_data;
    logic             p_we;
    logic [CFG_W-1:0] p_wdata;
    logic             p_fin;
    logic [CFG_W-1:0] p_rdata;

    cfgx_target_check #(
        .MAX_BUS  (MAX_BUS),
        .MAX_DEVFN(MAX_DEVFN)
    ) u_tgt (
        .bus      (req_q.bus),
        .devfn    (req_q.devfn),
        .offset   (req_q.offset),
        .target_ok(tgt_ok),
        .addr_word(tgt_aw)
    );

    cfgx_lane_steer u_steer (
        .word  (word_q),
        .offset(req_q.offset),
        .size  (req_q.size),
        .wdata (req_q.wdata),
        .rd_val(st_rd),
        .merged(st_merged)
    );

    cfgx_dn_port #(
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
        .ADDR_W        (DN_ADDR_W),
        .ADDR_REG_OFS  (ADDR_REG_OFS),
        .DATA_REG_OFS  (DATA_REG_OFS)
    ) u_port (
        .clk     (clk),
        .rst     (rst),
        .start   (p_start),
        .sel_data(p_sel_data),
        .we      (p_we),
        .wdata   (p_wdata),
        .dn_req  (dn_req),
        .dn_addr (dn_addr),
        .dn_we   (dn_we),
        .dn_wdata(dn_wdata),
        .dn_rdata(dn_rdata),
        .dn_done (dn_done),
        .dn_err  (dn_err),
        .fin     (p_fin),
        .rdata   (p_rdata)
    );

    assign req_ready = (state == ST_IDLE);

    always_comb begin
        p_start    = 1'b0;
        p_sel_data = 1'b0;
        p_we       = 1'b0;
        p_wdata    = aw_q;
        case (state)
            ST_WR_ADDR, ST_WR_ADDR2: begin
                p_start = !issued;
                p_we    = 1'b1;
            end
            ST_RD_DATA: begin
                p_start    = !issued;
                p_sel_data = 1'b1;
            end
            ST_WR_DATA: begin
                p_start    = !issued;
                p_sel_data = 1'b1;
                p_we       = 1'b1;
                p_wdata    = word_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            req_q     <= '0;
            ok_q      <= 1'b0;
            aw_q      <= '0;
            word_q    <= '0;
            issued    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_found <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (p_start) begin
                issued <= 1'b1;
            end
            if (p_fin) begin
                issued <= 1'b0;
            end
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q.bus    <= req_bus;
                        req_q.devfn  <= req_devfn;
                        req_q.offset <= req_offset;
                        req_q.size   <= cfgx_size_e'(req_size);
                        req_q.write  <= req_write;
                        req_q.wdata  <= req_wdata;
                        state        <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    ok_q  <= tgt_ok;
                    aw_q  <= tgt_aw;
                    state <= tgt_ok ? ST_WR_ADDR : ST_RESPOND;
                end
                ST_WR_ADDR: begin
                    if (p_fin) begin
                        if (req_q.write && is_full(req_q.size)) begin
                            word_q <= req_q.wdata;
                            state  <= ST_WR_DATA;
                        end else begin
                            state <= ST_RD_DATA;
                        end
                    end
                end
                ST_RD_DATA: begin
                    if (p_fin) begin
                        word_q <= p_rdata;
                        state  <= req_q.write ? ST_MERGE : ST_RESPOND;
                    end
                end
                ST_MERGE: begin
                    word_q <= st_merged;
                    state  <= ST_WR_ADDR2;
                end
                ST_WR_ADDR2: begin
                    if (p_fin) begin
                        state <= ST_WR_DATA;
                    end
                end
                ST_WR_DATA: begin
                    if (p_fin) begin
                        state <= ST_RESPOND;
                    end
                end
                ST_RESPOND: begin
                    rsp_valid <= 1'b1;
                    rsp_found <= ok_q;
                    if (!ok_q) begin
                        rsp_data <= ones_at(req_q.size);
                    end else if (req_q.write) begin
                        rsp_data <= '0;
                    end else begin
                        rsp_data <= st_rd;
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfgx_adapter_chk.sv
module cfgx_adapter_chk #(
    parameter int TIMEOUT_CYCLES = 16,
    parameter int DN_ADDR_W      = 12,
    parameter logic [DN_ADDR_W-1:0] ADDR_REG_OFS = 12'h500,
    parameter logic [DN_ADDR_W-1:0] DATA_REG_OFS = 12'h504,
    parameter int MAX_BUS        = 7,
    parameter int MAX_DEVFN      = 127
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [7:0]           req_bus,
    input logic [7:0]           req_devfn,
    input logic [1:0]           req_size,
    input logic                 req_write,
    input logic                 rsp_valid,
    input logic                 rsp_found,
    input logic                 dn_req,
    input logic [DN_ADDR_W-1:0] dn_addr,
    input logic                 dn_we,
    input logic [31:0]          dn_wdata
);
    localparam int HW = $clog2(TIMEOUT_CYCLES + 2);

    logic          bad_pend;
    logic          full_pend;
    logic [HW-1:0] hold_cnt;
    logic          accept;

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_pend  <= 1'b0;
            full_pend <= 1'b0;
            hold_cnt  <= '0;
        end else begin
            if (accept) begin
                bad_pend  <= (int'(req_bus) > MAX_BUS) || (int'(req_devfn) > MAX_DEVFN);
                full_pend <= req_write && req_size[1];
            end else if (rsp_valid) begin
                bad_pend  <= 1'b0;
                full_pend <= 1'b0;
            end
            if (dn_req) begin
                if (hold_cnt != {HW{1'b1}}) hold_cnt <= hold_cnt + 1'b1;
            end else begin
                hold_cnt <= '0;
            end
        end
    end

    a_r1_one_inflight: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

    a_r1_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r4_no_dn_cycle: assert property (@(posedge clk) disable iff (rst)
        bad_pend |-> !dn_req);

    a_r4_not_found: assert property (@(posedge clk) disable iff (rst)
        (bad_pend && rsp_valid) |-> !rsp_found);

    a_r2_addr_shape: assert property (@(posedge clk) disable iff (rst)
        (dn_req && dn_addr == ADDR_REG_OFS) |->
            (dn_we && dn_wdata[31:24] == 8'h00 && !dn_wdata[1]
             && (dn_wdata[0] == (dn_wdata[23:16] != 8'h00))));

    a_r3_known_reg: assert property (@(posedge clk) disable iff (rst)
        dn_req |-> (dn_addr == ADDR_REG_OFS || dn_addr == DATA_REG_OFS));

    a_r9_no_read_full_write: assert property (@(posedge clk) disable iff (rst)
        full_pend |-> !(dn_req && dn_addr == DATA_REG_OFS && !dn_we));

    a_r10_timeout_bound: assert property (@(posedge clk) disable iff (rst)
        dn_req |-> (int'(hold_cnt) < TIMEOUT_CYCLES));

    a_r11_dn_hold: assert property (@(posedge clk) disable iff (rst)
        (dn_req && $past(dn_req)) |->
            ($stable(dn_addr) && $stable(dn_we) && $stable(dn_wdata)));
endmodule

bind cfgx_adapter cfgx_adapter_chk #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .DN_ADDR_W     (DN_ADDR_W),
    .ADDR_REG_OFS  (ADDR_REG_OFS),
    .DATA_REG_OFS  (DATA_REG_OFS),
    .MAX_BUS       (MAX_BUS),
    .MAX_DEVFN     (MAX_DEVFN)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_bus  (req_bus),
    .req_devfn(req_devfn),
    .req_size (req_size),
    .req_write(req_write),
    .rsp_valid(rsp_valid),
    .rsp_found(rsp_found),
    .dn_req   (dn_req),
    .dn_addr  (dn_addr),
    .dn_we    (dn_we),
    .dn_wdata (dn_wdata)
);

// File: tb/cfgx_adapter_tb_top.sv
module cfgx_adapter_tb_top;
    localparam int TMO = 8;
    localparam logic [11:0] AREG = 12'h500;
    localparam logic [11:0] DREG = 12'h504;
    localparam logic [7:0]  SILENT_DEV = 8'h50;
    localparam logic [7:0]  ERR_DEV    = 8'h51;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_bus = '0;
    logic [7:0]  req_devfn = '0;
    logic [7:0]  req_offset = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_found;
    logic [31:0] rsp_data;
    logic        dn_req;
    logic [11:0] dn_addr;
    logic        dn_we;
    logic [31:0] dn_wdata;
    logic [31:0] dn_rdata = '0;
    logic        dn_done = 1'b0;
    logic        dn_err = 1'b0;

    int total = 0;
    int bad = 0;
    int rsp_seen = 0;

    always #5 clk = ~clk;

    cfgx_adapter #(.TIMEOUT_CYCLES(TMO)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_data(rsp_data),
        .dn_req(dn_req), .dn_addr(dn_addr), .dn_we(dn_we), .dn_wdata(dn_wdata),
        .dn_rdata(dn_rdata), .dn_done(dn_done), .dn_err(dn_err)
    );

    task automatic chk(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    // bridge model state
    logic [31:0] mem [logic [31:0]];
    logic [31:0] lat_aw = '0;
    logic [11:0] lg_a [$];
    logic        lg_we [$];
    logic [31:0] lg_d [$];

    function automatic logic [31:0] peek(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
    endfunction

    initial begin : bridge_model
        logic seen;
        logic answered;
        int   dly;
        logic [11:0] f_a;
        logic        f_we;
        logic [31:0] f_d;
        seen = 1'b0; answered = 1'b0; dly = 0;
        f_a = '0; f_we = 1'b0; f_d = '0;
        forever begin
            @(negedge clk);
            dn_done = 1'b0;
            dn_err  = 1'b0;
            if (!dn_req) begin
                seen = 1'b0;
                answered = 1'b0;
            end else begin
                if (!seen) begin
                    seen = 1'b1; dly = 0;
                    f_a = dn_addr; f_we = dn_we; f_d = dn_wdata;
                    lg_a.push_back(dn_addr); lg_we.push_back(dn_we); lg_d.push_back(dn_wdata);
                end else begin
                    dly++;
                end
                if (!answered && dly == 2) begin
                    chk(dn_addr == f_a && dn_we == f_we && dn_wdata == f_d,
                        "R11 downstream hold", dn_wdata, f_d);
                    if (dn_addr == AREG) begin
                        lat_aw = dn_wdata;
                        dn_done = 1'b1;
                        answered = 1'b1;
                    end else if (lat_aw[15:8] == ERR_DEV) begin
                        dn_err = 1'b1;
                        answered = 1'b1;
                    end else if (lat_aw[15:8] != SILENT_DEV) begin
                        if (dn_we) mem[lat_aw] = dn_wdata;
                        else dn_rdata = peek(lat_aw);
                        dn_done = 1'b1;
                        answered = 1'b1;
                    end
                end
            end
        end
    end

    // scoreboard
    logic [32:0] exp_q [$];

    initial begin : monitor
        logic prev;
        logic [32:0] e;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid) begin
                if (prev) chk(1'b0, "R1 response pulse longer than one cycle", 32'd1, 32'd0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected response", rsp_data, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    chk(rsp_data == e[31:0], "data (see request tag)", rsp_data, e[31:0]);
                    chk(rsp_found == e[32], "R4 R10 found flag", {31'b0, rsp_found}, {31'b0, e[32]});
                end
                rsp_seen++;
            end
            prev = rsp_valid;
        end
    end

    function automatic logic [31:0] ones_sz(input logic [1:0] sz);
        if (sz == 2'd0) return 32'h0000_00FF;
        if (sz == 2'd1) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic int shift_of(input logic [7:0] o, input logic [1:0] sz);
        if (sz == 2'd0) return (3 - int'(o[1:0])) * 8;
        if (sz == 2'd1) return o[1] ? 0 : 16;
        return 0;
    endfunction

    function automatic logic [31:0] mask_of(input logic [1:0] sz);
        return ones_sz(sz);
    endfunction

    function automatic logic [31:0] pick(input logic [31:0] w, input logic [7:0] o, input logic [1:0] sz);
        return (w >> shift_of(o, sz)) & mask_of(sz);
    endfunction

    function automatic logic [31:0] splice(input logic [31:0] w, input logic [7:0] o,
                                           input logic [1:0] sz, input logic [31:0] d);
        int s;
        s = shift_of(o, sz);
        return (w & ~(mask_of(sz) << s)) | ((d & mask_of(sz)) << s);
    endfunction

    task automatic do_req(input logic [7:0] b, input logic [7:0] d, input logic [7:0] o,
                          input logic [1:0] sz, input logic wr, input logic [31:0] wd,
                          input string rq);
        logic        ok;
        logic [31:0] aw;
        logic [31:0] word;
        logic [11:0] ea [$];
        logic        ewe [$];
        logic [31:0] ed [$];
        int          target;
        ok   = (b <= 8'd7) && (d <= 8'd127);
        aw   = {8'h00, b, d, o & 8'hFC} | {31'b0, (b != 8'h00)};
        word = (d == SILENT_DEV || d == ERR_DEV) ? 32'hFFFF_FFFF : peek(aw);
        if (!ok) begin
            exp_q.push_back({1'b0, ones_sz(sz)});
        end else if (!wr) begin
            ea.push_back(AREG); ewe.push_back(1'b1); ed.push_back(aw);
            ea.push_back(DREG); ewe.push_back(1'b0); ed.push_back(32'h0);
            exp_q.push_back({1'b1, pick(word, o, sz)});
        end else if (sz[1]) begin
            ea.push_back(AREG); ewe.push_back(1'b1); ed.push_back(aw);
            ea.push_back(DREG); ewe.push_back(1'b1); ed.push_back(wd);
            exp_q.push_back({1'b1, 32'h0});
        end else begin
            ea.push_back(AREG); ewe.push_back(1'b1); ed.push_back(aw);
            ea.push_back(DREG); ewe.push_back(1'b0); ed.push_back(32'h0);
            ea.push_back(AREG); ewe.push_back(1'b1); ed.push_back(aw);
            ea.push_back(DREG); ewe.push_back(1'b1); ed.push_back(splice(word, o, sz, wd));
            exp_q.push_back({1'b1, 32'h0});
        end
        lg_a.delete(); lg_we.delete(); lg_d.delete();
        target = rsp_seen + 1;
        @(negedge clk);
        req_bus = b; req_devfn = d; req_offset = o; req_size = sz;
        req_write = wr; req_wdata = wd; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R1 ready low while busy", {31'b0, req_ready}, 32'd0);
        while (rsp_seen < target) @(negedge clk);
        $display("checked request: %s", rq);
        chk(lg_a.size() == ea.size(), "R3 R8 R9 R4 downstream cycle count",
            lg_a.size(), ea.size());
        if (lg_a.size() == ea.size()) begin
            for (int i = 0; i < ea.size(); i++) begin
                chk(lg_a[i] == ea[i] && lg_we[i] == ewe[i], "R3 register order",
                    {19'b0, lg_we[i], lg_a[i]}, {19'b0, ewe[i], ea[i]});
                if (ewe[i]) chk(lg_d[i] == ed[i], "R2 R8 R9 downstream write word", lg_d[i], ed[i]);
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=%0d exp=%0d", rsp_seen, exp_q.size());
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : driver
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", {31'b0, req_ready}, 32'd1);
        chk(rsp_valid == 1'b0, "R1 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk(dn_req == 1'b0, "R1 reset dn_req", {31'b0, dn_req}, 32'd0);

        for (int k = 0; k < 4; k++)
            do_req(8'd0, 8'h08, 8'(k), 2'd0, 1'b0, 32'h0, "R5 byte read lane");
        do_req(8'd0, 8'h08, 8'h04, 2'd1, 1'b0, 32'h0, "R6 half read upper");
        do_req(8'd0, 8'h08, 8'h06, 2'd1, 1'b0, 32'h0, "R6 half read lower");
        do_req(8'd0, 8'h08, 8'h07, 2'd1, 1'b0, 32'h0, "R6 half read odd offset");
        do_req(8'd0, 8'h08, 8'h0B, 2'd2, 1'b0, 32'h0, "R7 word read misaligned");
        do_req(8'd0, 8'h09, 8'h0C, 2'd3, 1'b0, 32'h0, "R7 word read size 3");
        do_req(8'd3, 8'h21, 8'h3C, 2'd2, 1'b0, 32'h0, "R2 type1 word read");
        do_req(8'd7, 8'h7F, 8'hFD, 2'd0, 1'b0, 32'h0, "R2 edge target byte read");
        do_req(8'd8, 8'h00, 8'h00, 2'd0, 1'b0, 32'h0, "R4 bus 8 byte read");
        do_req(8'd0, 8'h80, 8'h02, 2'd1, 1'b0, 32'h0, "R4 devfn 128 half read");
        do_req(8'd9, 8'hFF, 8'h00, 2'd2, 1'b0, 32'h0, "R4 bad word read");
        do_req(8'd200, 8'h01, 8'h10, 2'd0, 1'b1, 32'h77, "R4 bad byte write");
        do_req(8'd0, 8'h10, 8'h10, 2'd2, 1'b1, 32'hDEAD_BEEF, "R9 R12 full write");
        do_req(8'd0, 8'h10, 8'h10, 2'd2, 1'b0, 32'h0, "R9 readback");
        do_req(8'd0, 8'h10, 8'h11, 2'd0, 1'b1, 32'hFFFF_FF5A, "R8 R12 byte write");
        do_req(8'd0, 8'h10, 8'h10, 2'd2, 1'b0, 32'h0, "R8 byte write readback");
        do_req(8'd0, 8'h10, 8'h12, 2'd1, 1'b1, 32'hABCD_1234, "R8 half write");
        do_req(8'd0, 8'h10, 8'h10, 2'd2, 1'b0, 32'h0, "R8 half write readback");
        do_req(8'd2, 8'h31, 8'h24, 2'd1, 1'b1, 32'h0000_9876, "R8 type1 half write");
        do_req(8'd2, 8'h31, 8'h24, 2'd2, 1'b0, 32'h0, "R8 type1 readback");
        do_req(8'd0, SILENT_DEV, 8'h00, 2'd2, 1'b0, 32'h0, "R10 timeout word read");
        do_req(8'd1, SILENT_DEV, 8'h02, 2'd0, 1'b0, 32'h0, "R10 timeout byte read");
        do_req(8'd0, ERR_DEV, 8'h04, 2'd1, 1'b0, 32'h0, "R10 error half read");
        do_req(8'd0, SILENT_DEV, 8'h01, 2'd0, 1'b1, 32'h0000_0012, "R10 R8 timeout byte write");
        do_req(8'd0, 8'h08, 8'h00, 2'd0, 1'b0, 32'h0, "R5 read after timeout");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R1 all responses seen", exp_q.size(), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule